// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is an up-counting timer for a chip's always-on domain. A slow reference clock arrives as a one-cycle pulse on `ref_tick_i`, synchronous to the system clock `clk_i`. A power-of-two prescaler, selected by its base-2 logarithm, divides the reference pulses. Each divided pulse advances a 32-bit counter while the run bit is set.

Three compare channels watch the counter. Channel 1 can also act as the wrap point. With wrap enabled, the counter goes back to zero on the tick after it has reached the channel 1 value, so it cycles through 0 up to that value. Each channel raises its own sticky flag when the counter becomes equal to that channel's value. The flags are masked by an enable register and combined into one interrupt line.

Software uses a single-cycle write port and a combinational read port. Word addresses:

| Address | Register |
|---|---|
| 0 | control |
| 1 | counter |
| 2 | flags (read-only) |
| 3 | interrupt enable |
| 4 | flag clear (write-only) |
| 8 + n | compare value of channel n |

Top module: `rtc_compare_timer`

## Requirements
- R1: After reset, all of the following read zero: control, counter, flags, interrupt enable and every compare register. `irq_o` is 0 after reset.
- R2: Control bits [7:4] hold k. While control bit 0 (run) is set, the counter advances by one on every 2^k-th `ref_tick_i` pulse, for k from 0 to 15. Counted from reset, N pulses give a count of floor(N / 2^k). The count rolls over from all ones to zero.
- R3: While the run bit is clear, the counter holds its value and ignores `ref_tick_i`. Setting run again resumes counting from the held value.
- R4: A write to address 1 loads the counter. If a tick falls in the same cycle, the written value wins. A counter write never sets a flag.
- R5: Control bit 1 enables wrap. With wrap set, a tick taken while the counter equals the channel 1 compare value loads zero. With wrap clear, the counter counts past that value.
- R6: Flag bit n (bit 0, 1 or 2 of address 2) is set on a tick after which the counter equals the channel n compare value. The flag is not set again on later cycles without a tick, even though the value still matches.
- R7: Writing ones to address 4 clears the matching flag bits. If hardware sets a flag in the same cycle as it is cleared, the flag ends up set.
- R8: `irq_o` is high exactly when at least one flag bit and its enable bit (address 3, same bit positions) are both set.
- R9: The compare registers, the interrupt enable register and the control fields read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle pulse from the slow reference clock |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bound checker checks, on every cycle, these local rules:
- the counter is held while stopped;
- a tick adds exactly one unless a wrap or a load applies;
- the wrap goes to zero;
- a load takes the written data;
- flags rise only on a tick;
- a clear without a tick leaves the cleared bits low;
- the interrupt needs a set flag and a nonzero enable.

Only the bench scenarios can show the following:
- the divide ratio over many pulses, for each prescaler setting;
- the full wrap sequence;
- that a matching value left stationary does not set a cleared flag again;
- the set-over-clear collision;
- the register readback.

// File: rtl/rtc_timer_pkg.sv
package rtc_timer_pkg;
  localparam int unsigned ADDR_W     = 4;
  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] A_COUNT    = 4'd1;
  localparam logic [ADDR_W-1:0] A_FLAGS    = 4'd2;
  localparam logic [ADDR_W-1:0] A_IEN      = 4'd3;
  localparam logic [ADDR_W-1:0] A_ICLR     = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMP_BASE = 4'd8;

  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_WRAP_BIT = 1;
  localparam int unsigned CTRL_LOG_LSB  = 4;

  typedef struct packed {
    logic [3:0] div_log2;
    logic       wrap_en;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRESC_W = 15,
  localparam int unsigned LOG_W  = $clog2(PRESC_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ref_tick_i,
  input  logic [LOG_W-1:0] div_log2_i,
  output logic             tick_o
);
  logic [PRESC_W-1:0] div_q;
  logic [PRESC_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PRESC_W; i++) begin
      mask[i] = (i < int'(div_log2_i));
    end
  end

  // free-running divider; only frozen while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (run_i && ref_tick_i) begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick_o = run_i && ref_tick_i && (&(div_q | ~mask));
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_CH  = 3,
  parameter int unsigned WRAP_CH = 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic                          wrap_en_i,
  input  logic                          cnt_we_i,
  input  logic [CNT_W-1:0]              cnt_wdata_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cmp_i,
  output logic [CNT_W-1:0]              cnt_o,
  output logic [NUM_CH-1:0]             match_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_adv;
  logic             at_top;

  assign at_top  = wrap_en_i && (cnt_q == cmp_i[WRAP_CH]);
  assign cnt_adv = at_top ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_we_i) begin
      cnt_q <= cnt_wdata_i;
    end else if (tick_i) begin
      cnt_q <= cnt_adv;
    end
  end

  // match on the value the counter is about to take
  for (genvar g = 0; g < NUM_CH; g++) begin : g_match
    assign match_o[g] = tick_i && !cnt_we_i && (cnt_adv == cmp_i[g]);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  input  logic [NUM_CH-1:0] ien_i,
  output logic [NUM_CH-1:0] flags_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_i) | set_i;
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & ien_i);
endmodule

// File: rtl/rtc_compare_timer.sv
module rtc_compare_timer
  import rtc_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_CH  = 3,
  parameter int unsigned WRAP_CH = 1,
  parameter int unsigned PRESC_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned LOG_W = $clog2(PRESC_W + 1);

  logic                         run_q, wrap_en_q;
  logic [LOG_W-1:0]             div_log2_q;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_q;
  logic [NUM_CH-1:0]            ien_q;
  logic [NUM_CH-1:0]            flags;
  logic [NUM_CH-1:0]            match;
  logic [NUM_CH-1:0]            clr;
  logic [CNT_W-1:0]             cnt;
  logic                         tick;
  logic                         cnt_we;
  logic                         ctrl_we, ien_we;

  assign ctrl_we = reg_we_i && (reg_addr_i == A_CTRL);
  assign ien_we  = reg_we_i && (reg_addr_i == A_IEN);
  assign cnt_we  = reg_we_i && (reg_addr_i == A_COUNT);
  assign clr     = (reg_we_i && (reg_addr_i == A_ICLR)) ? reg_wdata_i[NUM_CH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      wrap_en_q  <= 1'b0;
      div_log2_q <= '0;
      ien_q      <= '0;
    end else begin
      if (ctrl_we) begin
        run_q      <= reg_wdata_i[CTRL_RUN_BIT];
        wrap_en_q  <= reg_wdata_i[CTRL_WRAP_BIT];
        div_log2_q <= reg_wdata_i[CTRL_LOG_LSB +: LOG_W];
      end
      if (ien_we) ien_q <= reg_wdata_i[NUM_CH-1:0];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_q[g] <= '0;
      end else if (reg_we_i && (reg_addr_i == A_CMP_BASE + 4'(g))) begin
        cmp_q[g] <= reg_wdata_i;
      end
    end
  end

  rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .ref_tick_i (ref_tick_i),
    .div_log2_i (div_log2_q),
    .tick_o     (tick)
  );

  rtc_count_core #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .WRAP_CH(WRAP_CH)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .wrap_en_i   (wrap_en_q),
    .cnt_we_i    (cnt_we),
    .cnt_wdata_i (reg_wdata_i),
    .cmp_i       (cmp_q),
    .cnt_o       (cnt),
    .match_o     (match)
  );

  rtc_irq_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (match),
    .clr_i   (clr),
    .ien_i   (ien_q),
    .flags_o (flags),
    .irq_o   (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[CTRL_RUN_BIT]              = run_q;
        reg_rdata_o[CTRL_WRAP_BIT]             = wrap_en_q;
        reg_rdata_o[CTRL_LOG_LSB +: LOG_W]     = div_log2_q;
      end
      A_COUNT: reg_rdata_o = cnt;
      A_FLAGS: reg_rdata_o[NUM_CH-1:0] = flags;
      A_IEN:   reg_rdata_o[NUM_CH-1:0] = ien_q;
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (reg_addr_i == A_CMP_BASE + 4'(i)) reg_rdata_o = cmp_q[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/rtc_compare_timer_chk.sv
module rtc_compare_timer_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned NUM_CH = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              run_i,
  input logic              wrap_en_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  cmp_wrap_i,
  input logic              cnt_we_i,
  input logic [CNT_W-1:0]  wdata_i,
  input logic [NUM_CH-1:0] flags_i,
  input logic [NUM_CH-1:0] ien_i,
  input logic [NUM_CH-1:0] clr_i,
  input logic              irq_i
);
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_we_i && !(wrap_en_i && cnt_i == cmp_wrap_i))
      |=> cnt_i == $past(cnt_i) + 1'b1);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_we_i) |=> $stable(cnt_i));

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_i == $past(wdata_i));

  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_we_i && wrap_en_i && cnt_i == cmp_wrap_i) |=> cnt_i == '0);

  assert_flag_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_i & ~$past(flags_i)) != '0) |-> $past(tick_i));

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i != '0) && !tick_i) |=> ((flags_i & $past(clr_i)) == '0));

  assert_irq_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (flags_i != '0) && (ien_i != '0));
endmodule

bind rtc_compare_timer rtc_compare_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick),
  .run_i      (run_q),
  .wrap_en_i  (wrap_en_q),
  .cnt_i      (cnt),
  .cmp_wrap_i (cmp_q[WRAP_CH]),
  .cnt_we_i   (cnt_we),
  .wdata_i    (reg_wdata_i),
  .flags_i    (flags),
  .ien_i      (ien_q),
  .clr_i      (clr),
  .irq_i      (irq_o)
);

// File: tb/rtc_compare_timer_tb.sv
module rtc_compare_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CTRL = 0, A_CNT = 1, A_FLG = 2, A_IEN = 3, A_CLR = 4, A_CMP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_compare_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    we = 1'b0;
    ref_tick = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    ref_tick = 1'b1;
    repeat (n) @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1 reset state
    foreach (A_LIST[i]) ;
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_CNT, v);  check("R1 count", v, 0);
    rd(A_FLG, v);  check("R1 flags", v, 0);
    rd(A_IEN, v);  check("R1 ien", v, 0);
    for (int c = 0; c < 3; c++) begin
      rd(A_CMP + 4'(c), v); check("R1 cmp", v, 0);
    end
    check("R1 irq", {31'b0, irq}, 0);

    // R2 prescaler sweep: N = 4*2^k - 1 pulses -> count 3
    for (int k = 0; k <= 12; k++) begin
      int n;
      n = 4 * (1 << k) - 1;
      do_reset();
      wr(A_CTRL, 32'(1 | (k << 4)));
      ticks(n);
      rd(A_CNT, v); check("R2 divide", v, 32'(n >> k));
    end
    do_reset();
    wr(A_CTRL, 32'(1 | (15 << 4)));
    ticks(32768 + 3);
    rd(A_CNT, v); check("R2 divide k=15", v, 1);

    // R3 freeze and resume
    do_reset();
    wr(A_CTRL, 1);
    ticks(10);
    wr(A_CTRL, 0);
    ticks(20);
    rd(A_CNT, v); check("R3 frozen", v, 10);
    wr(A_CTRL, 1);
    ticks(5);
    rd(A_CNT, v); check("R3 resume", v, 15);

    // R4 load, rollover, load beats tick
    wr(A_CNT, 32'hFFFF_FFF0);
    ticks(20);
    rd(A_CNT, v); check("R2 rollover", v, 4);
    wr(A_CLR, 7);
    @(negedge clk);
    we = 1'b1; addr = A_CNT; wdata = 100; ref_tick = 1'b1;
    @(negedge clk);
    we = 1'b0; ref_tick = 1'b0;
    rd(A_CNT, v); check("R4 load wins", v, 100);
    rd(A_FLG, v); check("R4 no flag on load", v, 0);
    ticks(1);
    rd(A_CNT, v); check("R4 after load", v, 101);

    // R5 wrap at channel 1
    do_reset();
    wr(A_CMP + 1, 4);
    wr(A_CMP + 0, 9);
    wr(A_CTRL, 3);
    for (int i = 1; i <= 12; i++) begin
      ticks(1);
      rd(A_CNT, v); check("R5 wrap seq", v, 32'(i % 5));
    end
    rd(A_FLG, v); check("R6 ch1 flag", v & 2, 2);
    wr(A_CTRL, 1);
    wr(A_CNT, 0);
    ticks(7);
    rd(A_CNT, v); check("R5 no wrap", v, 7);

    // R6 flags with k=1, stationary match
    do_reset();
    wr(A_CMP + 0, 2);
    wr(A_CMP + 1, 100);
    wr(A_CMP + 2, 3);
    wr(A_CTRL, 32'(1 | (1 << 4)));
    ticks(4);
    rd(A_FLG, v); check("R6 ch0 set", v, 1);
    wr(A_CLR, 1);
    ticks(1);
    rd(A_CNT, v); check("R6 stationary count", v, 2);
    rd(A_FLG, v); check("R6 no reset", v, 0);
    ticks(1);
    rd(A_FLG, v); check("R6 ch2 set", v, 4);

    // R7 set beats clear; R8 irq masking
    wr(A_CTRL, 1);
    wr(A_CLR, 7);
    wr(A_CNT, 1);
    @(negedge clk);
    we = 1'b1; addr = A_CLR; wdata = 1; ref_tick = 1'b1;
    @(negedge clk);
    we = 1'b0; ref_tick = 1'b0;
    rd(A_FLG, v); check("R7 set wins", v, 1);
    check("R8 masked", {31'b0, irq}, 0);
    wr(A_IEN, 1);
    check("R8 enabled", {31'b0, irq}, 1);
    wr(A_IEN, 4);
    check("R8 other bit", {31'b0, irq}, 0);
    wr(A_IEN, 5);
    wr(A_CLR, 1);
    rd(A_FLG, v); check("R7 cleared", v, 0);
    check("R8 after clear", {31'b0, irq}, 0);

    // R9 readback
    wr(A_CMP + 0, 32'hDEAD_BEEF);
    wr(A_CMP + 2, 32'h1234_5678);
    wr(A_CTRL, 32'h0000_00A2);
    rd(A_CMP + 0, v); check("R9 cmp0", v, 32'hDEAD_BEEF);
    rd(A_CMP + 1, v); check("R9 cmp1", v, 100);
    rd(A_CMP + 2, v); check("R9 cmp2", v, 32'h1234_5678);
    rd(A_IEN, v);     check("R9 ien", v, 5);
    rd(A_CTRL, v);    check("R9 ctrl", v, 32'h0000_00A2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam int A_LIST [1] = '{0};
endmodule